// File: doc/BRIEF.md
# Split-View Condition Field Register File

This block holds eight 4-bit condition fields in a single storage array and exposes them through two kinds of port. Narrow ports reach one 4-bit field at a time. The field is picked by a one-hot select vector, not by a binary address. Full-width ports see all eight fields packed as one 32-bit word. The full-width write port carries a per-field enable mask, so it can update any subset of fields in one cycle.

There are three narrow read ports, two narrow write ports, one masked full-width write port, and two full-width read ports. The second full-width read port is meant for a debug agent. Every read port is write-through: it returns the value that will be stored at the coming clock edge, so a write made in the same cycle is visible at once. When several writers hit the same field in one cycle, a fixed priority picks one value. That value is both stored and bypassed to the readers.

All ports are plain combinational pins with no handshake. A set select bit or enable bit is the only qualifier, and the block never stalls a caller.

Top module: `crf_split_regs`

## Requirements
- R1: A synchronous active-high reset clears all eight fields to zero. After reset, with no write pending, both full-width reads return 0.
- R2: Narrow write port p (p = 0 or 1) writes `wr_data[p]` into every field whose bit is set in `wr_sel[p]` at the rising clock edge. Fields that are not written keep their value.
- R3: Narrow read port k returns the OR of all fields selected by `rd_sel[k]`. A single set bit i returns field i, and an all-zero select returns 4'h0.
- R4: In the 32-bit word, field i occupies bits [(7-i)*4+3 : (7-i)*4]. Field 0 is at [31:28] and field 7 is at [3:0]. A full-width write updates field i only when `wide_we[i]` is 1.
- R5: `wide_rdata` and `dbg_rdata` both return the full 32-bit word, independently of each other and of the narrow ports.
- R6: Every read port reflects writes presented in the same cycle (write-through). It never returns the stale stored value of a field being written.
- R7: When writers collide on one field, narrow port 1 beats narrow port 0, and narrow port 0 beats the full-width port.
- R8: A narrow write select with several bits set writes the same 4-bit value into each selected field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 3x8 | One-hot field select for each narrow read port |
| rd_data | output | 3x4 | Narrow read data, OR of the selected fields |
| wr_sel | input | 2x8 | One-hot field select for each narrow write port |
| wr_data | input | 2x4 | Narrow write data |
| wide_we | input | 8 | Per-field write enable for the full-width write, bit i = field i |
| wide_wdata | input | 32 | Full-width write data, field 0 in the top nibble |
| wide_rdata | output | 32 | Full-width read of all fields |
| dbg_rdata | output | 32 | Second full-width read, for debug access |

## Verification
The assertions assume that reset is held for at least one clock edge before the first check. They also assume that select and enable inputs are 0 or 1, never X, once reset is released. The hold property relies on the inputs being quiet for two consecutive cycles. The stimulus drives every input from a known value at each falling edge and asserts reset from time zero. It also inserts idle cycles between the write sweeps, so the retention and zero-select properties see real quiet windows.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int CRF_NF = 8;  // number of condition fields
  localparam int CRF_FW = 4;  // bits per field
  localparam int CRF_NRP = 3; // narrow read ports
  localparam int CRF_NWP = 2; // narrow write ports
endpackage

// File: rtl/crf_merge.sv
// Next-state merge: the full-width port has the lowest priority,
// and a higher-numbered narrow write port overrides a lower one.
module crf_merge #(
  parameter int NF  = 8,
  parameter int FW  = 4,
  parameter int NWP = 2
) (
  input  logic [NF-1:0][FW-1:0]  cur,
  input  logic [NF-1:0]          wide_we,
  input  logic [NF*FW-1:0]       wide_wdata,
  input  logic [NWP-1:0][NF-1:0] wr_sel,
  input  logic [NWP-1:0][FW-1:0] wr_data,
  output logic [NF-1:0][FW-1:0]  nxt
);
  always_comb begin
    for (int f = 0; f < NF; f++) begin
      nxt[f] = cur[f];
      if (wide_we[f]) nxt[f] = wide_wdata[(NF-1-f)*FW +: FW];
      for (int p = 0; p < NWP; p++) begin
        if (wr_sel[p][f]) nxt[f] = wr_data[p];
      end
    end
  end
endmodule

// File: rtl/crf_sel_read.sv
// One-hot narrow read: returns the OR of every selected field.
module crf_sel_read #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input  logic [NF-1:0]         sel,
  input  logic [NF-1:0][FW-1:0] fields,
  output logic [FW-1:0]         data
);
  always_comb begin
    data = '0;
    for (int f = 0; f < NF; f++) begin
      data |= fields[f] & {FW{sel[f]}};
    end
  end
endmodule

// File: rtl/crf_store.sv
// Field storage with synchronous reset.
module crf_store #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NF-1:0][FW-1:0] nxt,
  output logic [NF-1:0][FW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/crf_split_regs.sv
module crf_split_regs
  import crf_pkg::*;
#(
  parameter int NF  = CRF_NF,
  parameter int FW  = CRF_FW,
  parameter int NRP = CRF_NRP,
  parameter int NWP = CRF_NWP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NRP-1:0][NF-1:0] rd_sel,
  output logic [NRP-1:0][FW-1:0] rd_data,
  input  logic [NWP-1:0][NF-1:0] wr_sel,
  input  logic [NWP-1:0][FW-1:0] wr_data,
  input  logic [NF-1:0]          wide_we,
  input  logic [NF*FW-1:0]       wide_wdata,
  output logic [NF*FW-1:0]       wide_rdata,
  output logic [NF*FW-1:0]       dbg_rdata
);
  localparam int WW = NF * FW;

  logic [NF-1:0][FW-1:0] stored;
  logic [NF-1:0][FW-1:0] bypass;
  logic [WW-1:0]         packed_word;

  crf_merge #(.NF(NF), .FW(FW), .NWP(NWP)) u_merge (
    .cur        (stored),
    .wide_we    (wide_we),
    .wide_wdata (wide_wdata),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .nxt        (bypass)
  );

  crf_store #(.NF(NF), .FW(FW)) u_store (
    .clk (clk),
    .rst (rst),
    .nxt (bypass),
    .q   (stored)
  );

  // narrow readers see the merged (write-through) view
  for (genvar k = 0; k < NRP; k++) begin : g_rd
    crf_sel_read #(.NF(NF), .FW(FW)) u_rd (
      .sel    (rd_sel[k]),
      .fields (bypass),
      .data   (rd_data[k])
    );
  end

  // whole-word packing: field 0 in the most significant nibble
  for (genvar f = 0; f < NF; f++) begin : g_pack
    assign packed_word[(NF-1-f)*FW +: FW] = bypass[f];
  end

  assign wide_rdata = packed_word;
  assign dbg_rdata  = packed_word;
endmodule

// File: rtl/crf_split_regs_chk.sv
module crf_split_regs_chk #(
  parameter int NF  = 8,
  parameter int FW  = 4,
  parameter int NRP = 3,
  parameter int NWP = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NRP-1:0][NF-1:0] rd_sel,
  input logic [NRP-1:0][FW-1:0] rd_data,
  input logic [NWP-1:0][NF-1:0] wr_sel,
  input logic [NWP-1:0][FW-1:0] wr_data,
  input logic [NF-1:0]          wide_we,
  input logic [NF*FW-1:0]       wide_wdata,
  input logic [NF*FW-1:0]       wide_rdata,
  input logic [NF*FW-1:0]       dbg_rdata
);
  logic any_wr;
  assign any_wr = (|wide_we) | (|wr_sel);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !any_wr) |-> (wide_rdata == '0 && dbg_rdata == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!any_wr && !$past(any_wr) && !$past(rst)) |-> $stable(wide_rdata)); // R2

  for (genvar k = 0; k < NRP; k++) begin : g_zero
    AST_ZERO_SEL: assert property (@(posedge clk) disable iff (rst)
      (rd_sel[k] == '0) |-> (rd_data[k] == '0)); // R3
  end

  AST_FIELD0_MAP: assert property (@(posedge clk) disable iff (rst)
    (rd_sel[0] == NF'(1)) |-> (rd_data[0] == wide_rdata[NF*FW-1 -: FW])); // R4

  AST_TOP_PRIO_WT: assert property (@(posedge clk) disable iff (rst)
    (wr_sel[NWP-1][NF-1]) |-> (wide_rdata[FW-1:0] == wr_data[NWP-1])); // R7

  AST_WIDE_WT: assert property (@(posedge clk) disable iff (rst)
    (wide_we[0] && !wr_sel[0][0] && !wr_sel[NWP-1][0])
      |-> (dbg_rdata[NF*FW-1 -: FW] == wide_wdata[NF*FW-1 -: FW])); // R6
endmodule

bind crf_split_regs crf_split_regs_chk #(
  .NF(NF), .FW(FW), .NRP(NRP), .NWP(NWP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .wide_we    (wide_we),
  .wide_wdata (wide_wdata),
  .wide_rdata (wide_rdata),
  .dbg_rdata  (dbg_rdata)
);

// File: tb/tb_crf_split_regs.sv
module tb_crf_split_regs;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0][7:0]  rd_sel = '0;
  logic [2:0][3:0]  rd_data;
  logic [1:0][7:0]  wr_sel = '0;
  logic [1:0][3:0]  wr_data = '0;
  logic [7:0]       wide_we = '0;
  logic [31:0]      wide_wdata = '0;
  logic [31:0]      wide_rdata;
  logic [31:0]      dbg_rdata;

  int tests = 0;
  int fails = 0;
  logic [3:0] st [8];

  always #10 clk = ~clk; // 50 MHz

  crf_split_regs dut (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_sel(wr_sel), .wr_data(wr_data), .wide_we(wide_we),
    .wide_wdata(wide_wdata), .wide_rdata(wide_rdata), .dbg_rdata(dbg_rdata)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge with inputs already driven
  task automatic step(string tag);
    logic [3:0]  mg [8];
    logic [31:0] word;
    logic [3:0]  e;
    #5;
    for (int f = 0; f < 8; f++) begin
      mg[f] = st[f];
      if (wide_we[f])   mg[f] = wide_wdata[(7-f)*4 +: 4];
      if (wr_sel[0][f]) mg[f] = wr_data[0];
      if (wr_sel[1][f]) mg[f] = wr_data[1];
    end
    word = '0;
    for (int f = 0; f < 8; f++) word[(7-f)*4 +: 4] = mg[f];
    for (int k = 0; k < 3; k++) begin
      e = '0;
      for (int f = 0; f < 8; f++) if (rd_sel[k][f]) e |= mg[f];
      chk(tag, $sformatf("rd_data[%0d]", k), {28'd0, rd_data[k]}, {28'd0, e});
    end
    chk(tag, "wide_rdata", wide_rdata, word);
    chk(tag, "dbg_rdata", dbg_rdata, word);
    @(posedge clk);
    for (int f = 0; f < 8; f++) st[f] = rst ? 4'h0 : mg[f];
    @(negedge clk);
  endtask

  task automatic idle();
    wr_sel = '0; wide_we = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int f = 0; f < 8; f++) st[f] = 4'h0;
    repeat (3) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: cleared after reset, all read ports return zero
    rd_sel[0] = 8'hFF; rd_sel[1] = 8'h01; rd_sel[2] = 8'h80;
    step("R1");

    // R2/R6: narrow port 0 writes every value into every field
    for (int f = 0; f < 8; f++)
      for (int v = 0; v < 16; v++) begin
        wr_sel[0] = 8'(1 << f); wr_data[0] = 4'(v);
        rd_sel[0] = 8'(1 << f); rd_sel[1] = 8'(1 << ((f + 3) % 8)); rd_sel[2] = '0;
        step("R6");
      end
    idle(); step("R2"); step("R2");

    // R2: narrow port 1, varied values, read back next cycle
    for (int f = 0; f < 8; f++) begin
      wr_sel[1] = 8'(1 << f); wr_data[1] = 4'((f * 5 + 3) & 15);
      rd_sel[0] = '0; rd_sel[1] = 8'(1 << f); rd_sel[2] = 8'(1 << ((f + 1) % 8));
      step("R2");
    end
    idle(); step("R2");

    // R4: every full-width enable mask with a computed data pattern
    for (int m = 0; m < 256; m++) begin
      wide_we = 8'(m);
      wide_wdata = (32'(m) * 32'h0101_0101) ^ 32'h9E37_79B9 ^ {24'd0, 8'(m * 7)};
      rd_sel[0] = 8'(m); rd_sel[1] = ~8'(m); rd_sel[2] = 8'h80;
      step("R4");
    end
    idle(); step("R4"); step("R4");

    // R3: sweep every select pattern on every narrow read port
    for (int s = 0; s < 256; s++) begin
      rd_sel[0] = 8'(s); rd_sel[1] = 8'(s ^ 8'h5A); rd_sel[2] = 8'(255 - s);
      step("R3");
    end

    // R7: every collision combination on every field
    for (int f = 0; f < 8; f++)
      for (int c = 1; c < 8; c++) begin
        wide_we    = c[0] ? 8'(1 << f) : 8'h00;
        wide_wdata = {8{4'hA}};
        wr_sel[0]  = c[1] ? 8'(1 << f) : 8'h00; wr_data[0] = 4'h5;
        wr_sel[1]  = c[2] ? 8'(1 << f) : 8'h00; wr_data[1] = 4'hC;
        rd_sel[0]  = 8'(1 << f); rd_sel[1] = '0; rd_sel[2] = 8'hFF;
        step("R7");
      end
    idle(); step("R7");

    // R8: multi-bit narrow write selects
    for (int s = 1; s < 256; s += 17) begin
      wr_sel[0] = 8'(s); wr_data[0] = 4'(s & 15);
      rd_sel[0] = 8'(s); rd_sel[1] = 8'(~s); rd_sel[2] = 8'h01;
      step("R8");
      idle();
      step("R8");
    end

    // R5: both whole-word reads after idle
    rd_sel = '0;
    step("R5");

    // R1: reset again clears stored state
    rst = 1'b1; step("R1");
    rst = 1'b0; rd_sel[0] = 8'hFF; step("R1");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule